// File: doc/BRIEF.md
# Lattice Whitening Filter

This block is an eighth-order lattice analysis (whitening) filter for a low-power audio path. An external adaptive predictor supplies one reflection coefficient per stage. For each input sample the block runs the sample through the lattice and returns a prediction-error sample. Each stage derives a forward error and a backward error. The backward error that is kept for the next sample is first scaled by a constant leak factor below one. Every stored or forwarded value is brought back to a 16-bit fixed-point word by truncation toward zero. Any value that falls outside the word's range is clamped, and an overflow tally records it.

A single signed 16x16 multiplier with a 32-bit accumulator serves all stages in turn. The block takes three clock cycles per stage. A result is therefore ready long before the next sample arrives at audio rates. The surrounding logic raises `sampleValid` for one cycle with a new sample. It then waits for the one-cycle `outValid` pulse that carries the filtered value.

Top module: `lattice_whitener`

## Requirements
- R1: After reset `outValid` is low, `ovfCount` is zero and every delayed state is zero. The first sample after reset therefore comes out unchanged, whatever the coefficients are.
- R2: Samples, coefficients and outputs are two's complement with 2 integer and 14 fractional bits. Coefficient k(j), for j = 0..7, occupies `coefBank[16j+15:16j]`. `beta` is unsigned with value `beta`/4096.
- R3: Stage 0 sets the forward error f0 and the backward error b0 to the input sample. For stages i = 1..8, f(i) = Q(f(i-1) - k(i-1)·d(i-1)), where d(j) is the delayed state held from the previous sample.
- R4: For stages i = 1..7, b(i) = Q(d(i-1) - k(i-1)·f(i-1)), using the same previous-sample state d(i-1).
- R5: Once stage i has used d(i-1), the block replaces it with Q(beta/4096 · b(i-1)) from the current sample, for i = 1..8.
- R6: Q drops the 14 extra fractional bits of a product-width value by truncating toward zero. A negative value with a nonzero discarded part moves up by one LSB.
- R7: Q clamps a result above 32767 to 32767 and a result below -32768 to -32768. `ovfCount` rises by exactly one for each clamped f, b or d value.
- R8: `outSample` carries f8, and `outValid` goes high for exactly one cycle. The pulse comes 24 clock edges after the edge that accepted the sample.
- R9: A `sampleValid` pulse that arrives while a sample is still being processed is ignored. It produces no output, leaves the current result unchanged and leaves the delayed states unchanged.
- R10: Reset in the middle of a computation abandons it, clears the states and clears `ovfCount`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | One-cycle strobe: `sampleIn` is a new sample |
| sampleIn | input | 16 | Input sample, Q2.14 |
| coefBank | input | 128 | Eight Q2.14 reflection coefficients, k(j) at bits 16j+15:16j |
| beta | input | 12 | Leak factor for stored backward errors, unsigned, value beta/4096 |
| outValid | output | 1 | One-cycle strobe: `outSample` is valid |
| outSample | output | 16 | Filtered output f8, Q2.14 |
| ovfCount | output | 16 | Number of clamped requantizations since reset |

## Verification
The hardest conditions to reach from the ports are saturation and strobes that arrive while the filter is busy. Ordinary speech-like data never clamps, and a well-behaved source never strobes early. To force clamping, the stimulus drives a full-scale input through a coefficient of -2. This pushes the first backward error far past the range, and a second sample then feeds the clamped state back through the lattice. To exercise the busy case, the stimulus raises `sampleValid` with junk data on several cycles after a sample has been accepted. The next genuine sample must then match a reference that never saw the junk.

// File: rtl/lattice_pkg.sv
package lattice_pkg;

  // Strobes from the sequencer to the arithmetic datapath.
  typedef struct packed {
    logic load;     // capture a new sample into f0/b0
    logic doFwd;    // compute forward error of the current stage
    logic doBwd;    // compute backward error of the current stage
    logic doState;  // refresh the delayed state, advance the stage
    logic finish;   // last stage done: publish result
  } ctlT;

  typedef enum logic [1:0] {
    PH_FWD   = 2'd0,
    PH_BWD   = 2'd1,
    PH_STATE = 2'd2
  } phaseT;

endpackage

// File: rtl/lattice_requant.sv
// Converts a product-width value back to the sample word:
// truncation toward zero, then clamping with an overflow flag.
module lattice_requant #(
  parameter int DATA_W = 16,
  parameter int FRAC   = 14,
  parameter int ACC_W  = 2 * DATA_W
) (
  input  logic signed [ACC_W-1:0]  acc,
  output logic signed [DATA_W-1:0] qOut,
  output logic                     qOvf
);

  localparam logic signed [ACC_W-1:0] MAXV = (ACC_W'(1) <<< (DATA_W - 1)) - ACC_W'(1);
  localparam logic signed [ACC_W-1:0] MINV = ~MAXV;
  localparam logic signed [ACC_W-1:0] ONE  = ACC_W'(1);
  localparam logic signed [ACC_W-1:0] ZERO = '0;

  logic signed [ACC_W-1:0] shifted;
  logic signed [ACC_W-1:0] trunc;
  logic                    negFrac;

  always_comb begin
    shifted = acc >>> FRAC;
    negFrac = acc[ACC_W-1] & (|acc[FRAC-1:0]);
    trunc   = shifted + (negFrac ? ONE : ZERO);
    if (trunc > MAXV) begin
      qOut = MAXV[DATA_W-1:0];
      qOvf = 1'b1;
    end else if (trunc < MINV) begin
      qOut = MINV[DATA_W-1:0];
      qOvf = 1'b1;
    end else begin
      qOut = trunc[DATA_W-1:0];
      qOvf = 1'b0;
    end
  end

endmodule

// File: rtl/lattice_ctrl.sv
// Sequencer: three phases per stage, ORDER stages per sample.
module lattice_ctrl
  import lattice_pkg::*;
#(
  parameter int ORDER   = 8,
  parameter int STAGE_W = (ORDER > 1) ? $clog2(ORDER) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleValid,
  output ctlT                ctl,
  output logic [STAGE_W-1:0] stageIdx,
  output logic               busy
);

  localparam logic [STAGE_W-1:0] LAST = STAGE_W'(ORDER - 1);

  phaseT phase;
  logic  lastStage;

  assign lastStage = (stageIdx == LAST);

  always_comb begin
    ctl         = '0;
    ctl.load    = !busy && sampleValid;
    ctl.doFwd   = busy && (phase == PH_FWD);
    ctl.doBwd   = busy && (phase == PH_BWD) && !lastStage;
    ctl.doState = busy && (phase == PH_STATE);
    ctl.finish  = ctl.doState && lastStage;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      stageIdx <= '0;
      phase    <= PH_FWD;
    end else if (ctl.load) begin
      busy     <= 1'b1;
      stageIdx <= '0;
      phase    <= PH_FWD;
    end else if (busy) begin
      unique case (phase)
        PH_FWD:  phase <= PH_BWD;
        PH_BWD:  phase <= PH_STATE;
        default: begin
          phase <= PH_FWD;
          if (lastStage) busy <= 1'b0;
          else           stageIdx <= stageIdx + STAGE_W'(1);
        end
      endcase
    end
  end

endmodule

// File: rtl/lattice_datapath.sv
// Shared multiplier, accumulator, requantizer and lattice state.
module lattice_datapath
  import lattice_pkg::*;
#(
  parameter int ORDER   = 8,
  parameter int DATA_W  = 16,
  parameter int FRAC    = 14,
  parameter int BETA_W  = 12,
  parameter int CNT_W   = 16,
  parameter int STAGE_W = (ORDER > 1) ? $clog2(ORDER) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctlT                      ctl,
  input  logic [STAGE_W-1:0]       stageIdx,
  input  logic signed [DATA_W-1:0] sampleIn,
  input  logic [ORDER*DATA_W-1:0]  coefBank,
  input  logic [BETA_W-1:0]        beta,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outSample,
  output logic [CNT_W-1:0]         ovfCount
);

  localparam int ACC_W = 2 * DATA_W;
  localparam int BSH   = FRAC - BETA_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic signed [DATA_W-1:0] fCur, bCur, fTmp, bTmp;
  logic signed [DATA_W-1:0] dState [ORDER];

  logic signed [DATA_W-1:0] kSel, dSel, betaOp, opA, opB;
  logic signed [ACC_W-1:0]  prod, acc;
  logic signed [DATA_W-1:0] qVal;
  logic                     qOvf, qUsed;

  // Leak factor as an unsigned fraction aligned to the sample format.
  assign betaOp = signed'({{(DATA_W-BETA_W){1'b0}}, beta} << BSH);
  assign kSel   = signed'(coefBank[stageIdx*DATA_W +: DATA_W]);
  assign dSel   = dState[stageIdx];

  always_comb begin
    if (ctl.doState) begin
      opA = betaOp;
      opB = bCur;
    end else if (ctl.doBwd) begin
      opA = kSel;
      opB = fCur;
    end else begin
      opA = kSel;
      opB = dSel;
    end
  end

  assign prod = opA * opB;

  always_comb begin
    if (ctl.doState)    acc = prod;
    else if (ctl.doBwd) acc = (ACC_W'(dSel) <<< FRAC) - prod;
    else                acc = (ACC_W'(fCur) <<< FRAC) - prod;
  end

  lattice_requant #(
    .DATA_W(DATA_W),
    .FRAC  (FRAC),
    .ACC_W (ACC_W)
  ) requantInst (
    .acc (acc),
    .qOut(qVal),
    .qOvf(qOvf)
  );

  assign qUsed = ctl.doFwd | ctl.doBwd | ctl.doState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fCur      <= '0;
      bCur      <= '0;
      fTmp      <= '0;
      bTmp      <= '0;
      outValid  <= 1'b0;
      outSample <= '0;
      ovfCount  <= '0;
      for (int i = 0; i < ORDER; i++) dState[i] <= '0;
    end else begin
      outValid <= ctl.finish;
      if (ctl.load) begin
        fCur <= sampleIn;
        bCur <= sampleIn;
      end
      if (ctl.doFwd) fTmp <= qVal;
      if (ctl.doBwd) bTmp <= qVal;
      if (ctl.doState) begin
        dState[stageIdx] <= qVal;
        fCur             <= fTmp;
        bCur             <= bTmp;
      end
      if (ctl.finish) outSample <= fTmp;
      if (qUsed && qOvf && (ovfCount != CNT_MAX)) ovfCount <= ovfCount + CNT_W'(1);
    end
  end

endmodule

// File: rtl/lattice_whitener.sv
module lattice_whitener
  import lattice_pkg::*;
#(
  parameter int ORDER  = 8,
  parameter int DATA_W = 16,
  parameter int FRAC   = 14,
  parameter int BETA_W = 12,
  parameter int CNT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sampleValid,
  input  logic [DATA_W-1:0]       sampleIn,
  input  logic [ORDER*DATA_W-1:0] coefBank,
  input  logic [BETA_W-1:0]       beta,
  output logic                    outValid,
  output logic [DATA_W-1:0]       outSample,
  output logic [CNT_W-1:0]        ovfCount
);

  localparam int STAGE_W = (ORDER > 1) ? $clog2(ORDER) : 1;

  ctlT                ctl;
  logic [STAGE_W-1:0] stageIdx;
  logic               busy;
  logic signed [DATA_W-1:0] outSigned;

  lattice_ctrl #(
    .ORDER  (ORDER),
    .STAGE_W(STAGE_W)
  ) ctrlInst (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .ctl        (ctl),
    .stageIdx   (stageIdx),
    .busy       (busy)
  );

  lattice_datapath #(
    .ORDER  (ORDER),
    .DATA_W (DATA_W),
    .FRAC   (FRAC),
    .BETA_W (BETA_W),
    .CNT_W  (CNT_W),
    .STAGE_W(STAGE_W)
  ) dpInst (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .stageIdx (stageIdx),
    .sampleIn (signed'(sampleIn)),
    .coefBank (coefBank),
    .beta     (beta),
    .outValid (outValid),
    .outSample(outSigned),
    .ovfCount (ovfCount)
  );

  assign outSample = outSigned;

endmodule

// File: rtl/lattice_whitener_chk.sv
module lattice_whitener_chk #(
  parameter int ORDER = 8,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             sampleValid,
  input logic             busy,
  input logic             outValid,
  input logic [CNT_W-1:0] ovfCount
);

  localparam int LAT = 3 * ORDER;

  logic        pending;
  logic [15:0] latCnt;
  logic        accept;

  assign accept = sampleValid && !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
      latCnt  <= '0;
    end else if (accept) begin
      pending <= 1'b1;
      latCnt  <= '0;
    end else if (outValid) begin
      pending <= 1'b0;
    end else if (pending) begin
      latCnt <= latCnt + 16'd1;
    end
  end

  // R8
  out_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (pending && (latCnt == 16'(LAT))));

  // R8
  out_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  // R7
  ovf_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfCount == $past(ovfCount)) || (ovfCount == $past(ovfCount) + CNT_W'(1)));

  // R9
  idle_ovf_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(ovfCount));

endmodule

bind lattice_whitener lattice_whitener_chk #(
  .ORDER(ORDER),
  .CNT_W(CNT_W)
) chkInst (
  .clk        (clk),
  .rstN       (rstN),
  .sampleValid(sampleValid),
  .busy       (busy),
  .outValid   (outValid),
  .ovfCount   (ovfCount)
);

// File: tb/tb_lattice_whitener.sv
`timescale 1ns/1ps
module tb_lattice_whitener;

  localparam int ORDER = 8;
  localparam int LAT   = 3 * ORDER;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              sampleValid = 1'b0;
  logic [15:0]       sampleIn = '0;
  logic [ORDER*16-1:0] coefBank = '0;
  logic [11:0]       beta = 12'd0;
  logic              outValid;
  logic [15:0]       outSample;
  logic [15:0]       ovfCount;

  lattice_whitener dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .coefBank(coefBank), .beta(beta), .outValid(outValid),
    .outSample(outSample), .ovfCount(ovfCount)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int outstanding = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Reference model state
  int kv [ORDER];
  int dm [ORDER];
  int betaV = 0;
  int ovfModel = 0;

  // Scoreboard queues
  int expVal[$];
  int expOvf[$];
  int expCyc[$];
  string expTag[$];

  function automatic int quant(longint a);
    longint t = a / 16384;
    if (t > 32767) begin ovfModel++; return 32767; end
    if (t < -32768) begin ovfModel++; return -32768; end
    return int'(t);
  endfunction

  function automatic int modelStep(int x);
    int f = x, b = x, fn, bn, dp;
    for (int i = 0; i < ORDER; i++) begin
      dp = dm[i];
      fn = quant(longint'(f) * 16384 - longint'(kv[i]) * dp);
      bn = b;
      if (i < ORDER - 1) bn = quant(longint'(dp) * 16384 - longint'(kv[i]) * f);
      dm[i] = quant(longint'(betaV) * 4 * b);
      f = fn;
      b = bn;
    end
    return f;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setCoefs();
    for (int j = 0; j < ORDER; j++) coefBank[16*j +: 16] = kv[j][15:0];
    beta = betaV[11:0];
  endtask

  task automatic modelReset();
    for (int j = 0; j < ORDER; j++) dm[j] = 0;
    ovfModel = 0;
  endtask

  // Driver: push expectation, then strobe the sample. noise>0 adds ignored strobes.
  task automatic send(int x, string tag, int noise);
    int e;
    while (outstanding != 0) @(negedge clk);
    @(negedge clk);
    setCoefs();
    e = modelStep(x);
    sampleIn    = x[15:0];
    sampleValid = 1'b1;
    @(posedge clk);
    #1;
    expVal.push_back(e);
    expOvf.push_back(ovfModel);
    expCyc.push_back(cyc + LAT);
    expTag.push_back(tag);
    outstanding++;
    @(negedge clk);
    sampleValid = 1'b0;
    for (int n = 0; n < noise; n++) begin
      @(negedge clk);
      sampleValid = 1'b1;
      sampleIn    = 16'($urandom);
      @(negedge clk);
      sampleValid = 1'b0;
    end
  endtask

  // Monitor: pop and compare on every output strobe.
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (outstanding == 0) begin
        check(1'b0, "R9 unexpected output", int'($signed(outSample)), 0);
      end else begin
        int v, o, c;
        string t;
        v = expVal.pop_front();
        o = expOvf.pop_front();
        c = expCyc.pop_front();
        t = expTag.pop_front();
        check(int'($signed(outSample)) == v, {t, " value"}, int'($signed(outSample)), v);
        check(int'(ovfCount) == o, "R7 ovfCount", int'(ovfCount), o);
        check(cyc == c, "R8 latency", cyc, c);
        outstanding--;
      end
    end
  end

  // Single-cycle pulse check on the output strobe (R8)
  logic prevValid = 1'b0;
  always @(negedge clk) begin
    if (rstN && prevValid && outValid) check(1'b0, "R8 pulse width", 2, 1);
    prevValid <= outValid;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    modelReset();
    for (int j = 0; j < ORDER; j++) kv[j] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(outValid == 1'b0, "R1 outValid after reset", int'(outValid), 0);
    check(ovfCount == 16'd0, "R1 ovfCount after reset", int'(ovfCount), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1/R2: zero state passes the first sample through regardless of k
    for (int j = 0; j < ORDER; j++) kv[j] = int'($signed(16'($urandom_range(0, 16383)))) - 8192;
    betaV = 1024;
    send(-12345, "R1 first sample passthrough", 0);
    while (outstanding != 0) @(negedge clk);
    check(int'($signed(outSample)) == -12345, "R1 passthrough explicit", int'($signed(outSample)), -12345);

    // R3 R4 R5 R6: random samples and coefficients, leak in range
    for (int s = 0; s < 40; s++) begin
      if (s % 10 == 0) begin
        for (int j = 0; j < ORDER; j++) kv[j] = int'($urandom_range(0, 28000)) - 14000;
        betaV = int'($urandom_range(410, 2048));
      end
      send(int'($urandom_range(0, 24000)) - 12000, "R3 R4 R5 R6 lattice", 0);
    end

    // R6: small negative values that exercise truncation toward zero
    for (int j = 0; j < ORDER; j++) kv[j] = 3;
    betaV = 2047;
    for (int s = 0; s < 6; s++) send(-1 - s, "R6 negative truncation", 0);

    // R5: leak of zero empties the stored state after one sample
    betaV = 0;
    send(9000, "R5 zero leak", 0);
    send(-7000, "R5 state after zero leak", 0);

    // R9: junk strobes during computation are ignored
    for (int j = 0; j < ORDER; j++) kv[j] = int'($urandom_range(0, 16000)) - 8000;
    betaV = 1500;
    send(5000, "R9 with busy strobes", 9);
    send(-3000, "R9 state untouched", 0);

    // R7: saturation through full-scale input and coefficient -2
    for (int j = 0; j < ORDER; j++) kv[j] = -32768;
    betaV = 2048;
    send(32767, "R7 saturate", 0);
    send(-32768, "R7 saturate again", 0);
    while (outstanding != 0) @(negedge clk);
    check(int'(ovfCount) > 0, "R7 overflow observed", int'(ovfCount), ovfModel);

    // R10: reset mid-computation
    @(negedge clk);
    sampleIn = 16'd100;
    sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(ovfCount == 16'd0, "R10 ovfCount cleared", int'(ovfCount), 0);
    check(outValid == 1'b0, "R10 outValid cleared", int'(outValid), 0);
    rstN = 1'b1;
    modelReset();
    repeat (LAT + 4) @(negedge clk);
    check(outValid == 1'b0, "R10 abandoned sample gives no output", int'(outValid), 0);
    for (int j = 0; j < ORDER; j++) kv[j] = 12000;
    betaV = 800;
    send(4321, "R10 passthrough after reset", 0);
    send(-2222, "R10 follow-up", 0);

    while (outstanding != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule